// File: doc/BRIEF.md
# Eight-Input Programmable Interrupt Controller

The block gathers up to eight interrupt request lines. It decides which pending request the processor should serve, and it gives the processor a vector byte for that request. Software sets it up through a byte-wide port with one address bit, a chip select and separate write and read strobes.

After reset the block is dormant. A setup sequence starts with a start word. That word decides whether a cascade word and a mode word follow. Once the sequence is complete, the same port accepts run-time commands:
- a mask byte,
- end-of-service commands, either non-specific or for a given level, each with or without rotation,
- an explicit priority assignment.

Requests are captured on rising edges. A captured request that is not masked raises the interrupt output when it outranks every level already in service. Priority is a ring: the level named lowest has the level just above it, modulo eight, as the highest. An acknowledge pulse moves the winning request into service. The vector byte is the five upper bits of the programmed base with the 3-bit input number below them.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, and until a setup sequence has completed, the interrupt output stays low whatever the request lines do.
- R2: A write with the address bit low and data bit 4 set starts setup. Its bit 0 set means a mode word will come, and its bit 1 set means single mode. In single mode the cascade word is skipped. Otherwise the write after the base word (address bit high) is stored as the cascade mask and appears on `slaveMap`. After the last expected word, address-high writes load the mask.
- R3: Bit 2 of the start word is presented on `interval4` (set means an interval of 4).
- R4: The start word clears the mask, the in-service set and the captured requests, and it makes input 0 the highest priority.
- R5: Mask bit n set (written with the address bit high after setup) keeps input n from raising the interrupt output. Reading with the address bit high returns the mask. For example, 11h blocks inputs 0 and 4.
- R6: The interrupt output is high only when an unmasked captured request exists whose rank is above that of every level in service.
- R7: While the interrupt output is high, `vecOut` equals {base[7:3], winning input number}.
- R8: A one-cycle `intAck` while the output is high moves the winning bit from the captured requests into the in-service set. Reading with the address bit low returns the in-service set.
- R9: A command with the address bit low, bit 4 and bit 3 clear, and bits 7:5 = 001 clears the highest-ranked in-service bit.
- R10: Bits 7:5 = 101 does the same, and in addition makes the cleared input the lowest priority, so the next input up becomes the highest.
- R11: Bits 7:5 = 110 makes input bits 2:0 the lowest priority. For example, level 3 makes input 4 the highest.
- R12: Bits 7:5 = 011 clears only the in-service bit named by bits 2:0. If that bit is not set, the command has no effect.
- R13: A request is captured only on a rising edge of its line. A line that stays high raises no second interrupt after its first request has been served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select for the register port |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 1 | Register address bit |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data: in-service set (addr 0) or mask (addr 1) |
| irqIn | input | NUM_IN | Interrupt request lines |
| intAck | input | 1 | Acknowledge pulse from the processor |
| intOut | output | 1 | Interrupt request to the processor |
| vecOut | output | 8 | Vector byte for the current winner |
| slaveMap | output | NUM_IN | Stored cascade mask |
| interval4 | output | 1 | Call interval select from the start word |

## Verification
The bench builds the block with its default of eight inputs. With eight inputs the priority ring wraps across the 7-to-0 boundary, and a three-bit input number fills the low bits of the vector beneath a five-bit base field. The directed scenarios drive rotation and explicit priority assignment, so winners can be compared between inputs on both sides of that wrap. Nested service shows how a lower request waits behind a higher in-service level.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BASE,
    ST_CASC,
    ST_MODE,
    ST_RUN
  } seq_st_e;

  typedef struct packed {
    logic       ready;
    logic       initStart;
    logic       loadBase;
    logic       loadCascade;
    logic       loadMask;
    logic       eoi;
    logic       eoiSpecific;
    logic       rotate;
    logic       setPri;
    logic [7:0] data;
  } irqc_ctl_t;

endpackage

// File: rtl/irqc_seq.sv
module irqc_seq
  import irqc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cs,
  input  logic       wrEn,
  input  logic       addr,
  input  logic [7:0] wrData,
  output irqc_ctl_t  ctl
);

  seq_st_e state;
  logic    wantMode;
  logic    singleMode;

  logic wrLo, wrHi, startHit;
  assign wrLo     = cs && wrEn && !addr;
  assign wrHi     = cs && wrEn && addr;
  assign startHit = wrLo && wrData[4];

  always_comb begin
    ctl           = '0;
    ctl.data      = wrData;
    ctl.ready     = (state == ST_RUN);
    ctl.initStart = startHit;
    if (!startHit) begin
      unique case (state)
        ST_BASE: ctl.loadBase    = wrHi;
        ST_CASC: ctl.loadCascade = wrHi;
        ST_RUN: begin
          ctl.loadMask = wrHi;
          if (wrLo && !wrData[3]) begin
            unique case (wrData[7:5])
              3'b001: ctl.eoi = 1'b1;
              3'b011: begin ctl.eoi = 1'b1; ctl.eoiSpecific = 1'b1; end
              3'b101: begin ctl.eoi = 1'b1; ctl.rotate = 1'b1; end
              3'b111: begin ctl.eoi = 1'b1; ctl.eoiSpecific = 1'b1; ctl.rotate = 1'b1; end
              3'b110: ctl.setPri = 1'b1;
              default: ;
            endcase
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      wantMode   <= 1'b0;
      singleMode <= 1'b0;
    end else if (startHit) begin
      state      <= ST_BASE;
      wantMode   <= wrData[0];
      singleMode <= wrData[1];
    end else if (wrHi) begin
      unique case (state)
        ST_BASE: state <= singleMode ? (wantMode ? ST_MODE : ST_RUN) : ST_CASC;
        ST_CASC: state <= wantMode ? ST_MODE : ST_RUN;
        ST_MODE: state <= ST_RUN;
        default: ;
      endcase
    end
  end

  AST_SINGLE_SKIPS_CASC: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BASE && wrHi && !startHit && singleMode) |=> (state != ST_CASC)); // R2

  AST_CASC_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BASE && wrHi && !startHit && !singleMode) |=> (state == ST_CASC)); // R2

endmodule

// File: rtl/irqc_prio_pick.sv
module irqc_prio_pick #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec,
  input  logic [IDX_W-1:0] lowest,
  output logic             found,
  output logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] rank
);

  always_comb begin
    logic [IDX_W-1:0] pos;
    found = 1'b0;
    idx   = '0;
    rank  = '0;
    for (int r = N - 1; r >= 0; r--) begin
      pos = IDX_W'((int'(lowest) + 1 + r) % N);
      if (vec[pos]) begin
        found = 1'b1;
        idx   = pos;
        rank  = IDX_W'(r);
      end
    end
  end

endmodule

// File: rtl/irqc_core.sv
module irqc_core
  import irqc_pkg::*;
#(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rstN,
  input  irqc_ctl_t        ctl,
  input  logic [N-1:0]     irqIn,
  input  logic             intAck,
  output logic             intOut,
  output logic [7:0]       vecOut,
  output logic [N-1:0]     isrOut,
  output logic [N-1:0]     maskOut,
  output logic [N-1:0]     slaveMap,
  output logic             interval4
);

  localparam logic [N-1:0]     ONE_BIT = N'(1);
  localparam logic [IDX_W-1:0] LAST_IN = IDX_W'(N - 1);

  logic [N-1:0]     maskReg, irrReg, isrReg, reqPrev, cascReg;
  logic [IDX_W-1:0] lowestReg;
  logic [7:0]       baseReg;
  logic             int4Reg;

  logic             reqFound, isrFound;
  logic [IDX_W-1:0] reqIdx, reqRank, isrIdx, isrRank;
  logic [N-1:0]     pending, edges, ackBit, eoiBit;
  logic [IDX_W-1:0] level;

  assign pending = irrReg & ~maskReg;
  assign edges   = irqIn & ~reqPrev;
  assign level   = ctl.data[IDX_W-1:0];

  irqc_prio_pick #(.N(N), .IDX_W(IDX_W)) uReqPick (
    .vec(pending), .lowest(lowestReg), .found(reqFound), .idx(reqIdx), .rank(reqRank)
  );

  irqc_prio_pick #(.N(N), .IDX_W(IDX_W)) uIsrPick (
    .vec(isrReg), .lowest(lowestReg), .found(isrFound), .idx(isrIdx), .rank(isrRank)
  );

  assign intOut = ctl.ready && reqFound && (!isrFound || (reqRank < isrRank));
  assign vecOut = {baseReg[7:IDX_W], reqIdx};

  always_comb begin
    ackBit = (intAck && intOut) ? (ONE_BIT << reqIdx) : '0;
    eoiBit = '0;
    if (ctl.eoi) begin
      if (ctl.eoiSpecific)  eoiBit = ONE_BIT << level;
      else if (isrFound)    eoiBit = ONE_BIT << isrIdx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg   <= '0;
      irrReg    <= '0;
      isrReg    <= '0;
      reqPrev   <= '0;
      cascReg   <= '0;
      lowestReg <= LAST_IN;
      baseReg   <= '0;
      int4Reg   <= 1'b0;
    end else begin
      reqPrev <= irqIn;
      if (ctl.initStart) begin
        maskReg   <= '0;
        irrReg    <= '0;
        isrReg    <= '0;
        cascReg   <= '0;
        lowestReg <= LAST_IN;
        int4Reg   <= ctl.data[2];
      end else begin
        irrReg <= (irrReg | edges) & ~ackBit;
        isrReg <= (isrReg | ackBit) & ~eoiBit;
        if (ctl.loadBase)    baseReg <= ctl.data;
        if (ctl.loadCascade) cascReg <= ctl.data[N-1:0];
        if (ctl.loadMask)    maskReg <= ctl.data[N-1:0];
        if (ctl.setPri) begin
          lowestReg <= level;
        end else if (ctl.eoi && ctl.rotate) begin
          if (ctl.eoiSpecific)  lowestReg <= level;
          else if (isrFound)    lowestReg <= isrIdx;
        end
      end
    end
  end

  assign isrOut    = isrReg;
  assign maskOut   = maskReg;
  assign slaveMap  = cascReg;
  assign interval4 = int4Reg;

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.initStart |=> (maskReg == '0 && isrReg == '0 && irrReg == '0)); // R4

  AST_OUT_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> ((irrReg & ~maskReg) != '0)); // R5

  AST_OUT_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.ready |-> !intOut); // R1

  AST_ACK_ADDS_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && intOut && !ctl.eoi && !ctl.initStart)
      |=> ($countones(isrReg) == $countones($past(isrReg)) + 1)); // R8

  AST_EOI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.eoi && !ctl.eoiSpecific && isrReg != '0 && !intAck)
      |=> ($countones(isrReg) + 1 == $countones($past(isrReg)))); // R9

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_IN = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cs,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic [NUM_IN-1:0] irqIn,
  input  logic              intAck,
  output logic              intOut,
  output logic [7:0]        vecOut,
  output logic [NUM_IN-1:0] slaveMap,
  output logic              interval4
);

  localparam int IDX_W = $clog2(NUM_IN);

  irqc_ctl_t         ctl;
  logic [NUM_IN-1:0] isrOut, maskOut;

  irqc_seq uSeq (
    .clk(clk), .rstN(rstN), .cs(cs), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .ctl(ctl)
  );

  irqc_core #(.N(NUM_IN), .IDX_W(IDX_W)) uCore (
    .clk(clk), .rstN(rstN), .ctl(ctl), .irqIn(irqIn), .intAck(intAck),
    .intOut(intOut), .vecOut(vecOut), .isrOut(isrOut), .maskOut(maskOut),
    .slaveMap(slaveMap), .interval4(interval4)
  );

  always_comb begin
    rdData = '0;
    if (cs && rdEn) rdData = addr ? 8'(maskOut) : 8'(isrOut);
  end

endmodule

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cs = 1'b0, wrEn = 1'b0, rdEn = 1'b0, addr = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [7:0] irqIn = '0;
  logic       intAck = 1'b0;
  logic       intOut;
  logic [7:0] vecOut;
  logic [7:0] slaveMap;
  logic       interval4;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  irq_prio_ctrl dut (
    .clk(clk), .rstN(rstN), .cs(cs), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irqIn(irqIn), .intAck(intAck),
    .intOut(intOut), .vecOut(vecOut), .slaveMap(slaveMap), .interval4(interval4)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nTests++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    cs = 1'b0; wrEn = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    cs = 1'b1; rdEn = 1'b1; addr = a;
    #1 d = rdData;
    cs = 1'b0; rdEn = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] m);
    @(negedge clk); irqIn = irqIn | m;
    @(negedge clk); irqIn = irqIn & ~m;
  endtask

  task automatic ack();
    @(negedge clk); intAck = 1'b1;
    @(negedge clk); intAck = 1'b0;
  endtask

  task automatic setupSingle(input logic [7:0] base);
    wr(1'b0, 8'h13);
    wr(1'b1, base);
    wr(1'b1, 8'h01);
  endtask

  task automatic t_reset();
    pulse(8'h04);
    chk("R1 no output before setup", {7'd0, intOut}, 8'h00);
    wr(1'b0, 8'h13);
    wr(1'b1, 8'h40);
    pulse(8'h04);
    chk("R1 no output mid setup", {7'd0, intOut}, 8'h00);
  endtask

  task automatic t_setupForms();
    logic [7:0] d;
    wr(1'b0, 8'h17); wr(1'b1, 8'h48); wr(1'b1, 8'h01);
    chk("R2 single mode skips cascade", slaveMap, 8'h00);
    chk("R3 interval bit set", {7'd0, interval4}, 8'h01);
    rd(1'b1, d); chk("R4 mask cleared", d, 8'h00);
    wr(1'b1, 8'h11);
    rd(1'b1, d); chk("R2 mask loads after mode word", d, 8'h11);
    wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'hA5); wr(1'b1, 8'h01);
    chk("R2 cascade word stored", slaveMap, 8'hA5);
    chk("R3 interval bit clear", {7'd0, interval4}, 8'h00);
    wr(1'b0, 8'h10); wr(1'b1, 8'h20); wr(1'b1, 8'h0F); wr(1'b1, 8'hFF);
    rd(1'b1, d); chk("R2 no mode word then mask", d, 8'hFF);
    chk("R2 cascade second form", slaveMap, 8'h0F);
  endtask

  task automatic t_mask();
    setupSingle(8'h48);
    wr(1'b1, 8'h11);
    pulse(8'h11);
    chk("R5 masked inputs blocked", {7'd0, intOut}, 8'h00);
    pulse(8'h02);
    chk("R5 unmasked raises", {7'd0, intOut}, 8'h01);
    chk("R7 vector", vecOut, 8'h49);
  endtask

  task automatic t_nest();
    logic [7:0] d;
    setupSingle(8'h40);
    pulse(8'h08);
    chk("R7 vector input 3", vecOut, 8'h43);
    ack();
    rd(1'b0, d); chk("R8 in-service after ack", d, 8'h08);
    chk("R8 output drops after ack", {7'd0, intOut}, 8'h00);
    pulse(8'h20);
    chk("R6 lower request waits", {7'd0, intOut}, 8'h00);
    pulse(8'h02);
    chk("R6 higher request nests", {7'd0, intOut}, 8'h01);
    chk("R7 vector input 1", vecOut, 8'h41);
    ack();
    rd(1'b0, d); chk("R8 nested in-service", d, 8'h0A);
    wr(1'b0, 8'h20);
    rd(1'b0, d); chk("R9 clears highest", d, 8'h08);
    chk("R6 still blocked by 3", {7'd0, intOut}, 8'h00);
    wr(1'b0, 8'h20);
    rd(1'b0, d); chk("R9 clears last", d, 8'h00);
    chk("R6 pending 5 now raises", {7'd0, intOut}, 8'h01);
    chk("R7 vector input 5", vecOut, 8'h45);
    ack(); wr(1'b0, 8'h20);
  endtask

  task automatic t_rotate();
    setupSingle(8'h80);
    pulse(8'h04); ack();
    wr(1'b0, 8'hA0);
    pulse(8'h0A);
    chk("R10 after rotation input 3 wins", vecOut, 8'h83);
    setupSingle(8'h80);
    pulse(8'h82);
    chk("R4 setup restores input 0 order", vecOut, 8'h81);
  endtask

  task automatic t_setPri();
    logic [7:0] d;
    setupSingle(8'h00);
    wr(1'b0, 8'hC3);
    pulse(8'h19);
    chk("R11 input 4 highest", vecOut, 8'h04);
    ack();
    chk("R11 others below 4 wait", {7'd0, intOut}, 8'h00);
    wr(1'b0, 8'h64);
    rd(1'b0, d); chk("R12 specific clear", d, 8'h00);
    chk("R11 next in ring is 0", vecOut, 8'h00);
    ack();
    wr(1'b0, 8'h65);
    rd(1'b0, d); chk("R12 absent level no effect", d, 8'h01);
    wr(1'b0, 8'h60);
    rd(1'b0, d); chk("R12 clears level 0", d, 8'h00);
  endtask

  task automatic t_edge();
    setupSingle(8'h00);
    @(negedge clk); irqIn[6] = 1'b1;
    @(negedge clk);
    chk("R13 edge captured", {7'd0, intOut}, 8'h01);
    ack(); wr(1'b0, 8'h20);
    chk("R13 held line no repeat", {7'd0, intOut}, 8'h00);
    @(negedge clk); irqIn[6] = 1'b0;
    @(negedge clk); irqIn[6] = 1'b1;
    @(negedge clk);
    chk("R13 new edge captured", {7'd0, intOut}, 8'h01);
    irqIn[6] = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R1 reset output low", {7'd0, intOut}, 8'h00);
    t_reset();
    t_setupForms();
    t_mask();
    t_nest();
    t_rotate();
    t_setPri();
    t_edge();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nTests++; nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule